// File: doc/BRIEF.md
# Double-Word Arithmetic Shifter

This block performs an arithmetic shift on a pair of 36-bit words that are treated as one signed quantity. The sign is bit 35 of the high word. The magnitude is 70 bits long: high word bits 34..0 sit above low word bits 34..0. Bit 35 of the low word takes no part as data. When the magnitude moves across the word boundary, low bit 34 feeds high bit 0 directly. In the result, the low word's bit 35 is written with the sign.

An 18-bit offset gives the direction and the count. Bit 17 clear means a left shift. Bit 17 set means a right shift by the two's-complement negation of the offset. Left shifts fill with zeros and report any lost significance on two flags, overflow and trap. Right shifts fill with copies of the sign and never raise a flag.

Each operation is launched by a one-cycle start strobe. The results are registered and hold their value until the next strobe.

Top module: `dword_ash`

## Requirements
- R1: With offset bit 17 clear, the shift is left by offset bits 7..0. With bit 17 set, the shift is right by bits 7..0 of the 18-bit two's-complement negation of the offset. Offset bits 16..8 have no effect on a left shift.
- R2: The magnitude is {hi_in[34:0], lo_in[34:0]}, 70 bits wide. hi_in[35] is the sign, and it appears unchanged at hi_out[35]. hi_out[34:0] carries magnitude bits 69..35.
- R3: lo_out[34:0] carries magnitude bits 34..0. lo_out[35] always equals the sign, whatever the value of lo_in[35].
- R4: A left shift moves zeros in at magnitude bit 0. A left count of 70 or more clears the whole magnitude.
- R5: A right shift moves copies of the sign in at magnitude bit 69. A right count of 70 or more makes both words all zeros for a positive sign and all ones for a negative sign.
- R6: On a left shift, ovf_out and trap_out are both 1 exactly when some bit shifted out past magnitude bit 69 differs from the sign. The two flags are always equal.
- R7: A right shift leaves ovf_out and trap_out at 0.
- R8: A count of zero returns the magnitude and sign unchanged and sets no flag.
- R9: Results appear on the clock edge that samples start high. While start is low, all outputs hold.
- R10: While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch strobe: sample the operands on this edge |
| hi_in | input | 36 | High word; bit 35 is the sign |
| lo_in | input | 36 | Low word; bit 35 is ignored |
| offset | input | 18 | Direction (bit 17) and shift count |
| hi_out | output | 36 | Result high word |
| lo_out | output | 36 | Result low word; bit 35 equals the sign |
| ovf_out | output | 1 | Overflow flag for a left shift that loses significance |
| trap_out | output | 1 | Trap flag, raised together with overflow |

## Verification
All four results (both words and both flags) are due one clock edge after start is sampled high. They have no combinational path to the inputs.

The bench drives operands and start on a falling edge. It drops start on the next falling edge and compares every result there, half a cycle after the capturing rising edge. After that, it changes the inputs while start stays low and checks one falling edge later that nothing has moved.

// File: rtl/dwsh_pkg.sv
package dwsh_pkg;

  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } shdir_t;

endpackage

// File: rtl/dwsh_decode.sv
module dwsh_decode
  import dwsh_pkg::*;
#(
  parameter int OFF_W = 18,
  parameter int CNT_W = 8
) (
  input  logic [OFF_W-1:0] offset,
  output shdir_t           dir,
  output logic [CNT_W-1:0] count
);

  logic [OFF_W-1:0] neg_off;

  always_comb begin
    neg_off = ~offset + OFF_W'(1);
    dir     = offset[OFF_W-1] ? DIR_RIGHT : DIR_LEFT;
    count   = (dir == DIR_RIGHT) ? neg_off[CNT_W-1:0] : offset[CNT_W-1:0];
  end

endmodule

// File: rtl/dwsh_barrel.sv
module dwsh_barrel
  import dwsh_pkg::*;
#(
  parameter int MAG_W = 70,
  parameter int CNT_W = 8
) (
  input  logic [MAG_W-1:0] mag_in,
  input  logic             sign,
  input  shdir_t           dir,
  input  logic [CNT_W-1:0] count,
  output logic [MAG_W-1:0] mag_out
);

  localparam logic [MAG_W-1:0] ZEROS = '0;

  logic [MAG_W-1:0] stage [CNT_W+1];
  logic [MAG_W-1:0] fill;

  assign fill     = {MAG_W{sign}};
  assign stage[0] = mag_in;

  genvar k;
  generate
    for (k = 0; k < CNT_W; k++) begin : g_stage
      localparam int SH = 1 << k;
      if (SH >= MAG_W) begin : g_sat
        always_comb begin
          if (!count[k])
            stage[k+1] = stage[k];
          else if (dir == DIR_LEFT)
            stage[k+1] = ZEROS;
          else
            stage[k+1] = fill;
        end
      end else begin : g_mov
        always_comb begin
          if (!count[k])
            stage[k+1] = stage[k];
          else if (dir == DIR_LEFT)
            stage[k+1] = {stage[k][MAG_W-1-SH:0], ZEROS[SH-1:0]};
          else
            stage[k+1] = {fill[SH-1:0], stage[k][MAG_W-1:SH]};
        end
      end
    end
  endgenerate

  assign mag_out = stage[CNT_W];

endmodule

// File: rtl/dwsh_lossdet.sv
module dwsh_lossdet
  import dwsh_pkg::*;
#(
  parameter int MAG_W = 70,
  parameter int CNT_W = 8
) (
  input  logic [MAG_W-1:0] mag_in,
  input  logic             sign,
  input  shdir_t           dir,
  input  logic [CNT_W-1:0] count,
  output logic             lost
);

  logic [MAG_W-1:0] keep_mask;
  logic [MAG_W-1:0] out_mask;
  logic [MAG_W-1:0] differ;

  always_comb begin
    keep_mask = {MAG_W{1'b1}} >> count;
    out_mask  = ~keep_mask;
    differ    = mag_in ^ {MAG_W{sign}};
    lost      = (dir == DIR_LEFT) && (|(differ & out_mask));
  end

endmodule

// File: rtl/dword_ash.sv
module dword_ash
  import dwsh_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int OFF_W  = 18,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] hi_in,
  input  logic [WORD_W-1:0] lo_in,
  input  logic [OFF_W-1:0]  offset,
  output logic [WORD_W-1:0] hi_out,
  output logic [WORD_W-1:0] lo_out,
  output logic              ovf_out,
  output logic              trap_out
);

  localparam int HALF_W = WORD_W - 1;
  localparam int MAG_W  = 2 * HALF_W;

  shdir_t           dir;
  logic [CNT_W-1:0] count;
  logic             sign;
  logic [MAG_W-1:0] mag_in;
  logic [MAG_W-1:0] mag_sh;
  logic             lost;

  logic [WORD_W-1:0] hi_d, hi_q;
  logic [WORD_W-1:0] lo_d, lo_q;
  logic              ovf_d, ovf_q;
  logic              trap_d, trap_q;

  assign sign   = hi_in[WORD_W-1];
  assign mag_in = {hi_in[HALF_W-1:0], lo_in[HALF_W-1:0]};

  dwsh_decode #(.OFF_W(OFF_W), .CNT_W(CNT_W)) u_decode (
    .offset (offset),
    .dir    (dir),
    .count  (count)
  );

  dwsh_barrel #(.MAG_W(MAG_W), .CNT_W(CNT_W)) u_barrel (
    .mag_in  (mag_in),
    .sign    (sign),
    .dir     (dir),
    .count   (count),
    .mag_out (mag_sh)
  );

  dwsh_lossdet #(.MAG_W(MAG_W), .CNT_W(CNT_W)) u_lossdet (
    .mag_in (mag_in),
    .sign   (sign),
    .dir    (dir),
    .count  (count),
    .lost   (lost)
  );

  // next-state
  always_comb begin
    hi_d   = hi_q;
    lo_d   = lo_q;
    ovf_d  = ovf_q;
    trap_d = trap_q;
    if (start) begin
      hi_d   = {sign, mag_sh[MAG_W-1:HALF_W]};
      lo_d   = {sign, mag_sh[HALF_W-1:0]};
      ovf_d  = lost;
      trap_d = lost;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      ovf_q  <= 1'b0;
      trap_q <= 1'b0;
    end else begin
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      ovf_q  <= ovf_d;
      trap_q <= trap_d;
    end
  end

  assign hi_out   = hi_q;
  assign lo_out   = lo_q;
  assign ovf_out  = ovf_q;
  assign trap_out = trap_q;

endmodule

// File: rtl/dword_ash_chk.sv
module dword_ash_chk #(
  parameter int WORD_W = 36,
  parameter int OFF_W  = 18,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [WORD_W-1:0] hi_in,
  input logic [WORD_W-1:0] lo_in,
  input logic [OFF_W-1:0]  offset,
  input logic [WORD_W-1:0] hi_out,
  input logic [WORD_W-1:0] lo_out,
  input logic              ovf_out,
  input logic              trap_out
);

  localparam int HALF_W = WORD_W - 1;
  localparam int MAG_W  = 2 * HALF_W;

  logic              p_start;
  logic [WORD_W-1:0] p_hi, p_lo;
  logic [OFF_W-1:0]  p_off;
  logic [OFF_W-1:0]  p_neg;
  logic              p_sign;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_start <= 1'b0;
      p_hi    <= '0;
      p_lo    <= '0;
      p_off   <= '0;
    end else begin
      p_start <= start;
      p_hi    <= hi_in;
      p_lo    <= lo_in;
      p_off   <= offset;
    end
  end

  assign p_neg  = ~p_off + OFF_W'(1);
  assign p_sign = p_hi[WORD_W-1];

  // R2
  sign_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_start |-> hi_out[WORD_W-1] == p_sign);

  // R3
  low_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_start |-> lo_out[WORD_W-1] == p_sign);

  // R6
  flag_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_out == trap_out);

  // R7
  right_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_start && p_off[OFF_W-1]) |-> !ovf_out);

  // R8
  zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_start && !p_off[OFF_W-1] && p_off[CNT_W-1:0] == '0) |->
      (hi_out == p_hi && lo_out[HALF_W-1:0] == p_lo[HALF_W-1:0] && !ovf_out));

  // R5
  right_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_start && p_off[OFF_W-1] && int'(p_neg[CNT_W-1:0]) >= MAG_W) |->
      (hi_out == {WORD_W{p_sign}} && lo_out == {WORD_W{p_sign}}));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(hi_out) && $stable(lo_out) && $stable(ovf_out) && $stable(trap_out)));

endmodule

bind dword_ash dword_ash_chk #(.WORD_W(WORD_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/dword_ash_bench.sv
`timescale 1ns/1ps
module dword_ash_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [35:0] hi_in, lo_in;
  logic [17:0] offset;
  logic [35:0] hi_out, lo_out;
  logic        ovf_out, trap_out;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  dword_ash u_dword_ash (
    .clk(clk), .rst_n(rst_n), .start(start),
    .hi_in(hi_in), .lo_in(lo_in), .offset(offset),
    .hi_out(hi_out), .lo_out(lo_out), .ovf_out(ovf_out), .trap_out(trap_out)
  );

  task automatic check(string req, logic [71:0] act, logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %o expected %o", req, act, exp);
    end
  endtask

  // reference: one bit per step; returns {lost, hi, lo}
  function automatic logic [72:0] ref_shift(logic [35:0] h, logic [35:0] l, logic [17:0] off);
    logic        s;
    logic [69:0] m;
    logic        lost;
    logic [17:0] n;
    int          cnt;
    s    = h[35];
    m    = {h[34:0], l[34:0]};
    lost = 1'b0;
    n    = -off;
    if (!off[17]) begin
      cnt = int'(off[7:0]);
      for (int i = 0; i < cnt; i++) begin
        if (m[69] != s) lost = 1'b1;
        m = {m[68:0], 1'b0};
      end
    end else begin
      cnt = int'(n[7:0]);
      for (int i = 0; i < cnt; i++) m = {s, m[69:1]};
    end
    return {lost, s, m[69:35], s, m[34:0]};
  endfunction

  task automatic run_op(string tag, logic [35:0] h, logic [35:0] l, logic [17:0] off);
    logic [72:0] e;
    e = ref_shift(h, l, off);
    @(negedge clk);
    hi_in = h; lo_in = l; offset = off; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(tag, {36'd0, hi_out}, {36'd0, e[71:36]});
    check("R3", {36'd0, lo_out}, {36'd0, e[35:0]});
    check(off[17] ? "R7" : "R6", {70'd0, ovf_out, trap_out}, {70'd0, e[72], e[72]});
  endtask

  task automatic check_direct(string tag, logic [35:0] h, logic [35:0] l, logic [17:0] off,
                              logic [35:0] eh, logic [35:0] el);
    run_op(tag, h, l, off);
    check(tag, {hi_out, lo_out}, {eh, el});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; hi_in = '0; lo_in = '0; offset = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", {hi_out, lo_out}, 72'd0);
    check("R10", {70'd0, ovf_out, trap_out}, 72'd0);
    rst_n = 1'b1;

    // directed cases with known results (R4, R5, R3)
    check_direct("R4", 36'o000111222333, 36'o777666555444, 18'd6,
                 36'o011122233377, 36'o366655544400);
    check_direct("R5", 36'o000111222333, 36'o777666555444, 18'h3FFF7,
                 36'o000000111222, 36'o155777666555);
    check_direct("R5", 36'o000111222333, 36'o777666555444, 18'h3FFD4,
                 36'o000000000000, 36'o000000111222);
    check_direct("R4", 36'o0, 36'o000666555444, 18'd41,
                 36'o066655544400, 36'o0);
    // saturation corners
    check_direct("R4", 36'o400000000000, 36'o400000000000, 18'd76,
                 36'o400000000000, 36'o400000000000);
    check_direct("R5", 36'o777777777777, 36'o777777777777, 18'h3FFB4,
                 36'o777777777777, 36'o777777777777);
    check_direct("R5", 36'o412345670123, 36'o0, 18'h3FF00 + 18'd1,
                 36'o777777777777, 36'o777777777777);
    // R8 zero count, lo bit35 normalised
    check_direct("R8", 36'o123456701234, 36'o765432107654, 18'd0,
                 36'o123456701234, 36'o365432107654);
    // R1 upper offset bits ignored on left; right count from negation
    check_direct("R1", 36'o000000000001, 36'o0, 18'h0FF03,
                 36'o000000000010, 36'o0);
    check_direct("R1", 36'o000000000010, 36'o0, 18'h3FFFD,
                 36'o000000000001, 36'o0);
    // R6 overflow: positive word loses a one; negative word shifts out a zero
    run_op("R6", 36'o200000000000, 36'o0, 18'd1);
    check("R6", {71'd0, ovf_out}, 72'd1);
    run_op("R6", 36'o577777777777, 36'o0, 18'd1);
    check("R6", {71'd0, ovf_out}, 72'd1);
    run_op("R6", 36'o777777777777, 36'o777777777777, 18'd69);
    check("R6", {71'd0, ovf_out}, 72'd0);
    run_op("R6", 36'o0, 36'o000000000001, 18'd70);
    check("R6", {71'd0, ovf_out}, 72'd1);

    // R9 hold while start low
    begin
      logic [71:0] snap;
      snap = {hi_out, lo_out};
      @(negedge clk);
      hi_in = 36'o123123123123; lo_in = 36'o321321321321; offset = 18'd5;
      @(negedge clk);
      check("R9", {hi_out, lo_out}, snap);
      check("R9", {70'd0, ovf_out, trap_out}, {70'd0, 1'b1, 1'b1});
    end

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [35:0] h, l;
      logic [17:0] off;
      logic [7:0]  c;
      h = {$urandom, $urandom} ;
      l = {$urandom, $urandom};
      case ($urandom % 4)
        0: c = 8'($urandom % 8);
        1: c = 8'(30 + $urandom % 12);
        2: c = 8'(64 + $urandom % 10);
        default: c = 8'($urandom);
      endcase
      if ($urandom % 4 == 0) h = {h[35], {35{h[35]}} ^ (35'($urandom) & 35'h7)};
      if ($urandom % 2 == 0) begin
        off = {1'b0, 9'($urandom), c};
        run_op("R4", h, l, off);
      end else begin
        off = -{10'd0, c};
        if (c == 8'd0) off = 18'h20000;
        run_op("R5", h, l, off);
      end
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule